// File: doc/BRIEF.md
# Programmable Serial Baud Rate Generator

This block derives the bit-rate clocks of a serial link controller from one fast system clock. A 16-bit time-constant word sets it up. Its upper twelve bits hold a reload value for a down counter. Two 2-bit fields pick the ratios of two prescalers placed one after the other. A mode input selects where counting ticks come from. One choice is a half-rate tick made from the system clock. The other is the rising edges of an external receive clock, which is first synchronised.

The counter reloads on every terminal count, and this drives a first prescaler that divides by 1 or 16. The result is the primary rate, used as the transmit and receive bit clock. A second prescaler divides the primary rate by 1, 16 or 32 to make a slower rate for a clock-recovery loop. Each rate is given as a one-cycle enable pulse and as a level that toggles once per pulse. The primary level can be echoed to the transmit-clock pin, but only when neither transmit nor receive is set to take its clock from that pin.

A write to the time-constant word takes effect only at the next reload of the counter. A period that has already started is never cut short or stretched.

Top module: `baud_gen`

## Requirements
- R1: With both prescalers at divide-by-1 and tick source 0, `rate1_pulse` repeats every 2*(N+1) clock cycles, where N is the reload field `tc_wdata[15:4]`. N=0 is legal and gives a pulse on every tick.
- R2: The first-prescaler field `tc_wdata[3:2]` divides the terminal-count rate by 1 when it is 00 and by 16 for any other value.
- R3: The second-prescaler field `tc_wdata[1:0]` sets the spacing of `rate2_pulse` to 1 (code 00), 16 (code 01) or 32 (codes 10, 11) `rate1_pulse` pulses. Every `rate2_pulse` falls in a cycle that also has `rate1_pulse`.
- R4: In reset, and in the cycle after `run_en` rises, both levels are high. After `run_en` rises with N reload and divide-by-1, the first `rate1_pulse` is seen after the (2N+2)-th rising clock edge that follows the load edge.
- R5: A time-constant write changes nothing in the period already counting. The period loaded at the next reload uses the new value. A write sampled on the same edge as a reload is applied one reload later.
- R6: With `src_sel`=0 a counting tick occurs every second clock cycle. With `src_sel`=1 a tick occurs once per rising edge of `ext_rxc`, taken through a two-flop synchroniser.
- R7: While `run_en` is low there are no rate pulses and both levels hold their values.
- R8: `rate1_level` toggles on every `rate1_pulse` and `rate2_level` toggles on every `rate2_pulse`, and neither changes otherwise while running.
- R9: `pin_oe` is high exactly when `pin_is_txclk` and `pin_is_rxclk` are both low. `pin_clk` equals `rate1_level` when `pin_oe` is high and is 0 otherwise.
- R10: A change of either prescaler field is also deferred to the next counter reload. The running period keeps its old division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; a rising edge performs a fresh start-up load |
| src_sel | input | 1 | Tick source: 0 half-rate system tick, 1 external clock edges |
| tc_we | input | 1 | Time-constant write strobe |
| tc_wdata | input | 16 | Time-constant word: [15:4] reload, [3:2] prescaler 1, [1:0] prescaler 2 |
| ext_rxc | input | 1 | External receive clock, asynchronous |
| pin_is_txclk | input | 1 | Transmit clock is taken from the pin |
| pin_is_rxclk | input | 1 | Receive clock is taken from the pin |
| rate1_pulse | output | 1 | One-cycle pulse at the primary rate |
| rate1_level | output | 1 | Square wave toggling on each primary pulse |
| rate2_pulse | output | 1 | One-cycle pulse at the recovery-loop rate |
| rate2_level | output | 1 | Square wave toggling on each recovery-loop pulse |
| pin_oe | output | 1 | Drive enable for the echo on the transmit-clock pin |
| pin_clk | output | 1 | Echoed primary level for the pin |

## Verification
A time-constant write can land on the same clock edge as a counter reload. In that case the reload must take the value already held, and the new word waits one more period. The bench finds the reload edge from the last observed pulse and the known period. It raises the write strobe so that the strobe is sampled on exactly that edge. It then checks that the next two pulse intervals still show the old period and the third shows the new one. The same pulse-interval measurement is used to judge writes away from a reload, for both the count and the prescaler fields.

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int CW = 12,
  localparam int TW = CW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          src_sel,
  input  logic          tc_we,
  input  logic [TW-1:0] tc_wdata,
  input  logic          ext_rxc,
  input  logic          pin_is_txclk,
  input  logic          pin_is_rxclk,
  output logic          rate1_pulse,
  output logic          rate1_level,
  output logic          rate2_pulse,
  output logic          rate2_level,
  output logic          pin_oe,
  output logic          pin_clk
);

  logic [TW-1:0] tc_reg;
  logic [1:0]    rx_sync;
  logic          rx_prev;
  logic          run, half;
  logic [CW-1:0] cnt;
  logic [1:0]    sh_p1, sh_p2;
  logic [3:0]    p1cnt;
  logic [4:0]    p2cnt;
  logic [4:0]    p2_lim;

  wire tick   = src_sel ? (rx_sync[1] & ~rx_prev) : half;
  wire active = run_en & run;
  wire tc_hit = active & tick & (cnt == '0);
  wire p1_on  = |sh_p1;
  wire ev1    = tc_hit & (~p1_on | (p1cnt == 4'hF));
  wire ev2    = ev1 & (p2cnt >= p2_lim);

  always_comb begin
    case (sh_p2)
      2'b00:   p2_lim = 5'd0;
      2'b01:   p2_lim = 5'd15;
      default: p2_lim = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_reg  <= '0;
      rx_sync <= '0;
      rx_prev <= 1'b0;
    end else begin
      if (tc_we) tc_reg <= tc_wdata;
      rx_sync <= {rx_sync[0], ext_rxc};
      rx_prev <= rx_sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run         <= 1'b0;
      half        <= 1'b0;
      cnt         <= '0;
      sh_p1       <= '0;
      sh_p2       <= '0;
      p1cnt       <= '0;
      p2cnt       <= '0;
      rate1_level <= 1'b1;
      rate2_level <= 1'b1;
      rate1_pulse <= 1'b0;
      rate2_pulse <= 1'b0;
    end else begin
      rate1_pulse <= ev1;
      rate2_pulse <= ev2;
      if (!run_en) begin
        run <= 1'b0;
      end else if (!run) begin
        run         <= 1'b1;
        half        <= 1'b0;
        cnt         <= tc_reg[TW-1:4];
        sh_p1       <= tc_reg[3:2];
        sh_p2       <= tc_reg[1:0];
        p1cnt       <= '0;
        p2cnt       <= '0;
        rate1_level <= 1'b1;
        rate2_level <= 1'b1;
      end else begin
        half <= ~half;
        if (tick) begin
          if (cnt == '0) begin
            cnt   <= tc_reg[TW-1:4];
            sh_p1 <= tc_reg[3:2];
            sh_p2 <= tc_reg[1:0];
            p1cnt <= p1_on ? 4'(p1cnt + 4'd1) : 4'd0;
            if (ev1) p2cnt <= (p2cnt >= p2_lim) ? 5'd0 : 5'(p2cnt + 5'd1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (ev1) rate1_level <= ~rate1_level;
        if (ev2) rate2_level <= ~rate2_level;
      end
    end
  end

  assign pin_oe  = ~(pin_is_txclk | pin_is_rxclk);
  assign pin_clk = pin_oe & rate1_level;

  a_r1_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> cnt == $past(tc_reg[TW-1:4]));

  a_r3_rate2_within_rate1: assert property (@(posedge clk) disable iff (!rst_n)
    rate2_pulse |-> rate1_pulse);

  a_r4_startup_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> (rate1_level && rate2_level));

  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_en && !tc_hit) |=> ($stable(sh_p1) && $stable(sh_p2) && $stable(cnt) || !tick || $past(tick)));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!rate1_pulse && !rate2_pulse));

  a_r8_level_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    rate1_pulse |-> rate1_level != $past(rate1_level));

endmodule

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, src_sel = 1'b0, tc_we = 1'b0;
  logic [15:0] tc_wdata = '0;
  logic ext_rxc = 1'b0, pin_is_txclk = 1'b0, pin_is_rxclk = 1'b0;
  logic rate1_pulse, rate1_level, rate2_pulse, rate2_level, pin_oe, pin_clk;
  int checks = 0, fails = 0;
  int cyc = 0, last1 = 0, last2 = 0, per1 = 0, per2 = 0, n1 = 0, n2 = 0, n1s2 = 0, c12 = 0;
  int tog_bad = 0;
  logic pl1 = 1'b1, pl2 = 1'b1;
  bit rx_run = 0;

  always #5 clk = ~clk;

  baud_gen u0 (.clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel), .tc_we(tc_we),
    .tc_wdata(tc_wdata), .ext_rxc(ext_rxc), .pin_is_txclk(pin_is_txclk), .pin_is_rxclk(pin_is_rxclk),
    .rate1_pulse(rate1_pulse), .rate1_level(rate1_level), .rate2_pulse(rate2_pulse),
    .rate2_level(rate2_level), .pin_oe(pin_oe), .pin_clk(pin_clk));

  always @(negedge clk) begin
    cyc++;
    if (rate1_pulse) begin
      per1 = cyc - last1; last1 = cyc; n1++; n1s2++;
      if (rate1_level == pl1) tog_bad++;
    end
    if (rate2_pulse) begin
      per2 = cyc - last2; last2 = cyc; n2++; c12 = n1s2; n1s2 = 0;
      if (rate2_level == pl2) tog_bad++;
    end
    pl1 = rate1_level; pl2 = rate2_level;
  end

  initial begin
    forever begin
      #30;
      if (rx_run) ext_rxc = ~ext_rxc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic write_tc(input int n, input int a, input int b);
    @(negedge clk);
    tc_wdata = {12'(n), 2'(a), 2'(b)};
    tc_we = 1'b1;
    @(negedge clk);
    tc_we = 1'b0;
  endtask

  task automatic restart();
    run_en = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic wait1(input int k, input int lim);
    int base = n1;
    for (int i = 0; i < lim && n1 < base + k; i++) @(posedge clk);
  endtask

  task automatic wait2(input int k, input int lim);
    int base = n2;
    for (int i = 0; i < lim && n2 < base + k; i++) @(posedge clk);
  endtask

  function automatic int pdiv1(input int a); return (a == 0) ? 1 : 16; endfunction
  function automatic int pdiv2(input int b); return (b == 0) ? 1 : (b == 1) ? 16 : 32; endfunction

  task automatic sweep_one(input int n, input int a, input int b);
    int e1 = 2 * (n + 1) * pdiv1(a);
    int e2 = e1 * pdiv2(b);
    write_tc(n, a, b);
    restart();
    wait2(3, 4 * e2 + 100);
    chk(per1 == e1, (a == 0) ? "R1 period" : "R2 prescaler1", per1, e1);
    chk(per2 == e2, "R3 rate2 period", per2, e2);
    chk(c12 == pdiv2(b), "R3 rate1 pulses per rate2", c12, pdiv2(b));
  endtask

  initial begin
    int nv[4] = '{0, 1, 2, 4};
    int first;
    logic hl1, hl2;
    int bad;
    repeat (3) @(negedge clk);
    chk(rate1_pulse == 0 && rate2_pulse == 0, "R4 reset pulses", rate1_pulse + rate2_pulse, 0);
    chk(rate1_level && rate2_level, "R4 reset levels high", rate1_level + rate2_level, 2);
    rst_n = 1'b1;

    // R4: start-up level and first pulse position
    write_tc(2, 0, 0);
    run_en = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
    first = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 1) chk(rate1_level && rate2_level, "R4 start-up levels", rate1_level + rate2_level, 2);
      if (rate1_pulse && first == 0) first = k;
    end
    chk(first == 7, "R4 first pulse edge", first, 7);

    // R1, R2, R3 sweep
    foreach (nv[i])
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 3; b++)
          sweep_one(nv[i], a, b);
    sweep_one(0, 3, 3);

    // R5: write away from reload
    write_tc(3, 0, 0);
    restart();
    wait1(3, 200);
    @(negedge clk);
    tc_wdata = {12'd7, 2'd0, 2'd0}; tc_we = 1'b1;
    @(negedge clk);
    tc_we = 1'b0;
    wait1(1, 200);
    chk(per1 == 8, "R5 running period kept", per1, 8);
    wait1(1, 200);
    chk(per1 == 16, "R5 new period after reload", per1, 16);

    // R5: write sampled on the reload edge
    write_tc(3, 0, 0);
    restart();
    wait1(3, 200);
    repeat (7) @(negedge clk);
    tc_wdata = {12'd7, 2'd0, 2'd0}; tc_we = 1'b1;
    @(negedge clk);
    tc_we = 1'b0;
    wait1(1, 200);
    chk(per1 == 8, "R5 coincident: current period", per1, 8);
    wait1(1, 200);
    chk(per1 == 8, "R5 coincident: old value reloaded", per1, 8);
    wait1(1, 200);
    chk(per1 == 16, "R5 coincident: new value one reload later", per1, 16);

    // R10: prescaler field deferred
    write_tc(3, 0, 0);
    restart();
    wait1(3, 200);
    @(negedge clk);
    tc_wdata = {12'd3, 2'd1, 2'd0}; tc_we = 1'b1;
    @(negedge clk);
    tc_we = 1'b0;
    wait1(1, 400);
    chk(per1 == 8, "R10 running division kept", per1, 8);
    wait1(1, 400);
    chk(per1 == 128, "R10 new division after reload", per1, 128);

    // R6: external clock source, period 6 cycles
    src_sel = 1'b1; rx_run = 1;
    write_tc(1, 0, 0);
    restart();
    wait1(4, 400);
    chk(per1 == 12, "R6 external source N=1", per1, 12);
    write_tc(0, 0, 0);
    restart();
    wait1(4, 400);
    chk(per1 == 6, "R6 external source N=0", per1, 6);
    rx_run = 0; src_sel = 1'b0;

    // R7: freeze while disabled
    write_tc(0, 0, 0);
    restart();
    wait1(3, 100);
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    hl1 = rate1_level; hl2 = rate2_level;
    bad = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (rate1_pulse || rate2_pulse || rate1_level != hl1 || rate2_level != hl2) bad++;
    end
    chk(bad == 0, "R7 frozen while disabled", bad, 0);

    // R9: pin echo
    run_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      pin_is_txclk = m[0]; pin_is_rxclk = m[1];
      for (int k = 0; k < 6; k++) begin
        #1;
        bad = (pin_oe !== (m == 0)) || (pin_clk !== ((m == 0) & rate1_level));
        chk(bad == 0, "R9 echo gating", {pin_oe, pin_clk}, {(m == 0), ((m == 0) & rate1_level)});
        @(negedge clk);
      end
    end
    pin_is_txclk = 1'b0; pin_is_rxclk = 1'b0;

    // R8: level toggled on every pulse
    chk(tog_bad == 0, "R8 level toggles", tog_bad, 0);

    summary();
    $finish;
  end

  initial begin
    #(10 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule